// File: doc/BRIEF.md
# Debug Command Decoder and Executor

This block sits behind the host side of a debug link. It accepts whole debug commands that are already deserialized: an 8-bit opcode together with a 16-bit address word and a 16-bit data word. It decodes the fixed hardware command set and performs byte or word reads and writes on target memory. It does this by raising a bus request and waiting for a grant, so no arbitration happens inside the block. Read results go back to the host on a response stream. Hardware commands run whether or not the CPU is halted.

A small debug status byte lives at address FF01 of the debug register space. This space is visible only to the in-map opcodes. Bit 7 is the firmware-enable flag. Bit 6 mirrors the CPU's halted state, so the byte reads 00, 80 or C0 in the three usual situations. A host turns firmware commands on by reading this byte, setting its top bit and writing it back with the byte-write opcode. A halt (background entry) request opcode is honoured only while that flag is set.

Both streams use valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low for as long as the block is busy, and a held command then waits. A response transfers where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the block holds `rsp_data` steady and accepts no new command.

Top module: `dbg_cmd_exec`

## Requirements
- R1: A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both high. From the acceptance of a bus or response command until its write completes or its response is taken, `busy` is high and `cmd_ready` is low, and a command offered then is not taken.
- R2: Read opcodes are E4 (byte, debug space in), EC (word, debug space in), E0 (byte, debug space out) and E8 (word, debug space out). `bus_inmap` is 1 for E4/EC and 0 for E0/E8 during the access.
- R3: A byte read places the addressed byte in `rsp_data[7:0]` when address bit 0 is 1 and in `rsp_data[15:8]` when it is 0; the other byte is 00. A byte read drives `bus_be` 01 for odd addresses and 10 for even ones.
- R4: Opcode C4 writes one byte with the debug space in: `bus_be` is 01 with the low data byte for an odd address, and 10 with the high data byte for an even address. The other byte of memory keeps its value.
- R5: Word accesses present address bit 0 as 0 on `bus_addr` and drive `bus_be` 11, even when the command address is odd.
- R6: In-map accesses to FF00/FF01 never touch the bus. FF01 reads `{fw_en, cpu_halted, 000000}`, and FF00 reads 00. `fw_en` is 0 after reset and is loaded from data bit 7 by a C4 write to FF01. Writes to FF00 have no effect.
- R7: Out-of-map reads of FF00/FF01 go to the bus like any other address.
- R8: Opcode 90 produces exactly one cycle of `halt_req` when `fw_en` is 1, and nothing when it is 0.
- R9: An unrecognized opcode is accepted and dropped. It causes no bus access and no response, and it leaves the status byte unchanged.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays unchanged.
- R11: `bus_req` stays high with a steady address and direction until an edge where `bus_grant` is high. The access completes on that edge, and read data is taken from `bus_rdata` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 16 | Command address word |
| cmd_wdata | input | 16 | Command data word (write lanes by address parity) |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Host takes the result |
| rsp_data | output | 16 | Read result, byte placed by address parity |
| bus_req | output | 1 | Memory access request |
| bus_grant | input | 1 | Access completes on this edge |
| bus_we | output | 1 | 1 = write |
| bus_inmap | output | 1 | 1 = debug register space mapped in |
| bus_addr | output | 16 | Access address |
| bus_be | output | 2 | Byte enables, bit 1 = high byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with grant |
| cpu_halted | input | 1 | CPU is in background mode |
| busy | output | 1 | Command in progress |
| fw_enabled | output | 1 | Firmware-enable flag |
| halt_req | output | 1 | One-cycle background entry request |

## Verification
Take the edge that accepts a command as edge A. A status-space read raises `rsp_valid` right after edge A. A status write changes `fw_enabled` right after edge A. `halt_req` is high for the one cycle after edge A. A bus command raises `bus_req` after edge A, completes on the edge where `bus_grant` is high, and its response is valid from that edge. The bench drives inputs and samples outputs on falling edges. It pushes each expected response into a queue before the command goes out, and the monitor pops the queue only on a falling edge that shows a transfer about to happen. This means a late grant or host back-pressure shifts when the check runs, but not what it expects. Checks that nothing happened (unknown opcodes, rejected commands, a refused halt request) wait until `busy` is low and the queue is empty. They then compare access counters, pulse counters and read-back values.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam logic [7:0] OP_RD_BYTE_IN  = 8'hE4;
  localparam logic [7:0] OP_RD_WORD_IN  = 8'hEC;
  localparam logic [7:0] OP_RD_BYTE_OUT = 8'hE0;
  localparam logic [7:0] OP_RD_WORD_OUT = 8'hE8;
  localparam logic [7:0] OP_WR_BYTE_IN  = 8'hC4;
  localparam logic [7:0] OP_HALT_REQ    = 8'h90;

  typedef struct packed {
    logic known;
    logic rd;
    logic wr;
    logic word;
    logic inmap;
    logic halt;
  } cmd_dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} exec_st_t;
endpackage

// File: rtl/dbg_decode.sv
module dbg_decode
  import dbg_cmd_pkg::*;
(
  input  logic [7:0] op,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    unique case (op)
      OP_RD_BYTE_IN:  begin dec.known = 1'b1; dec.rd = 1'b1; dec.inmap = 1'b1; end
      OP_RD_WORD_IN:  begin dec.known = 1'b1; dec.rd = 1'b1; dec.word = 1'b1; dec.inmap = 1'b1; end
      OP_RD_BYTE_OUT: begin dec.known = 1'b1; dec.rd = 1'b1; end
      OP_RD_WORD_OUT: begin dec.known = 1'b1; dec.rd = 1'b1; dec.word = 1'b1; end
      OP_WR_BYTE_IN:  begin dec.known = 1'b1; dec.wr = 1'b1; dec.inmap = 1'b1; end
      OP_HALT_REQ:    begin dec.known = 1'b1; dec.halt = 1'b1; end
      default:        dec = '0;
    endcase
  end
endmodule

// File: rtl/dbg_lane.sv
module dbg_lane #(
  parameter int DATA_W = 16
) (
  input  logic              addr_lsb,
  input  logic              word,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0] rdata_out
);
  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // lane 0 (low byte) serves odd addresses, upper lane serves even ones
    assign be[g] = word | (addr_lsb == (g == 0));
    assign rdata_out[g*8 +: 8] = be[g] ? rdata_in[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dbg_status.sv
module dbg_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       cpu_halted,
  output logic       fw_en,
  output logic [7:0] stat_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fw_en <= 1'b0;
    else if (wr_en) fw_en <= wr_byte[7];
  end

  assign stat_val = {fw_en, cpu_halted, 6'b000000};

  // R6
  fw_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fw_en) |-> $past(wr_en));
endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] STAT_ADDR = 16'hFF01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_we,
  output logic              bus_inmap,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_halted,
  output logic              busy,
  output logic              fw_enabled,
  output logic              halt_req
);
  localparam int LANES = DATA_W / 8;

  exec_st_t          state;
  cmd_dec_t          dec;
  logic              accept, hit_stat, stat_wr;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, word_q, inmap_q;
  logic [DATA_W-1:0] wdata_q, rsp_q;
  logic [7:0]        stat_val;
  logic              lane_lsb, lane_word;
  logic [DATA_W-1:0] lane_in, lane_out;
  logic [LANES-1:0]  lane_be;

  dbg_decode u_dec (.op(cmd_op), .dec(dec));

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign hit_stat  = dec.inmap && (cmd_addr[ADDR_W-1:1] == STAT_ADDR[ADDR_W-1:1]);
  assign eff_addr  = dec.word ? {cmd_addr[ADDR_W-1:1], 1'b0} : cmd_addr;
  assign stat_wr   = accept && dec.wr && hit_stat && (cmd_addr[0] == STAT_ADDR[0]);

  dbg_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wr_byte(cmd_wdata[7:0]),
    .cpu_halted(cpu_halted), .fw_en(fw_enabled), .stat_val(stat_val)
  );

  // one lane unit: status placement while idle, bus lanes during an access
  assign lane_lsb  = (state == ST_IDLE) ? cmd_addr[0] : addr_q[0];
  assign lane_word = (state == ST_IDLE) ? dec.word    : word_q;
  assign lane_in   = (state == ST_IDLE) ? {{(DATA_W-8){1'b0}}, stat_val} : bus_rdata;

  dbg_lane #(.DATA_W(DATA_W)) u_lane (
    .addr_lsb(lane_lsb), .word(lane_word), .rdata_in(lane_in),
    .be(lane_be), .rdata_out(lane_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      word_q   <= 1'b0;
      inmap_q  <= 1'b0;
      wdata_q  <= '0;
      rsp_q    <= '0;
      halt_req <= 1'b0;
    end else begin
      halt_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept && dec.known) begin
            if (dec.halt) begin
              halt_req <= fw_enabled;
            end else if (hit_stat) begin
              if (dec.rd) begin
                rsp_q <= lane_out;
                state <= ST_RESP;
              end
            end else begin
              addr_q  <= eff_addr;
              we_q    <= dec.wr;
              word_q  <= dec.word;
              inmap_q <= dec.inmap;
              wdata_q <= cmd_wdata;
              state   <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (bus_grant) begin
            if (we_q) begin
              state <= ST_IDLE;
            end else begin
              rsp_q <= lane_out;
              state <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req   = (state == ST_BUS);
  assign bus_we    = we_q;
  assign bus_inmap = inmap_q;
  assign bus_addr  = addr_q;
  assign bus_be    = lane_be;
  assign bus_wdata = wdata_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_data  = rsp_q;

  // R1
  req_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cmd_valid));
  // R11
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  // R5
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_be == {LANES{1'b1}}) |-> !bus_addr[0]);
  // R4
  write_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> $onehot(bus_be));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R8
  halt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> fw_enabled && !$past(halt_req));
endmodule

// File: tb/dbg_cmd_exec_tb_top.sv
module dbg_cmd_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] cmd_addr = 16'h0000;
  logic [15:0] cmd_wdata = 16'h0000;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic        bus_we, bus_inmap;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_be;
  logic        cpu_halted = 1'b0;
  logic        busy, fw_enabled, halt_req;

  always #10 clk = ~clk;

  dbg_cmd_exec dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_we(bus_we),
    .bus_inmap(bus_inmap), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_halted(cpu_halted), .busy(busy), .fw_enabled(fw_enabled),
    .halt_req(halt_req)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return {8'(i) ^ 8'h5A, 8'(i) ^ 8'hC3};
  endfunction

  // target memory model
  logic [15:0] mem [256];
  int          n_access = 0;
  int          gnt_delay = 1;
  int          wait_cnt = 0;
  logic [15:0] last_addr;
  logic [1:0]  last_be;
  logic        last_inmap;

  assign bus_rdata = mem[bus_addr[8:1]];

  always @(posedge clk) begin
    if (bus_req && bus_grant) begin
      n_access++;
      last_addr  = bus_addr;
      last_be    = bus_be;
      last_inmap = bus_inmap;
      if (bus_we) begin
        if (bus_be[1]) mem[bus_addr[8:1]][15:8] = bus_wdata[15:8];
        if (bus_be[0]) mem[bus_addr[8:1]][7:0]  = bus_wdata[7:0];
      end
    end
    #1;
    if (bus_grant) begin
      bus_grant = 1'b0;
      wait_cnt  = 0;
    end else if (bus_req) begin
      if (wait_cnt >= gnt_delay) bus_grant = 1'b1;
      else wait_cnt++;
    end
  end

  // host back-pressure
  bit bp_on = 1'b0;
  int bp_cnt = 0;
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    rsp_ready = bp_on ? bp_cnt[1] : 1'b1;
  end

  int halt_cnt = 0;
  always @(posedge clk) if (halt_req) halt_cnt++;

  // scoreboard
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] held_data;
  bit          held = 1'b0;

  always @(negedge clk) begin
    if (held) begin
      // R10
      chk(rsp_valid && rsp_data == held_data, "R10 held response", rsp_data, held_data);
      held = 1'b0;
    end
    if (rsp_valid && !rsp_ready) begin
      held = 1'b1;
      held_data = rsp_data;
    end
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected response", rsp_data, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] op, input logic [15:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    send(op, a, 16'h0000);
    settle();
  endtask

  initial begin
    int acc0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !busy && !rsp_valid && !bus_req, "R1 reset idle", {12'h0, cmd_ready, busy, rsp_valid, bus_req}, 16'h0008);
    chk(!fw_enabled && !halt_req, "R6 reset flags", {14'h0, fw_enabled, halt_req}, 16'h0000);
    rst_n = 1'b1;

    // R6 status after reset, no bus use
    acc0 = n_access;
    rd(8'hE4, 16'hFF01, 16'h0000, "R6 status reset read");
    chk(n_access == acc0, "R6 status read no bus", 16'(n_access), 16'(acc0));

    // R8 refused while disabled
    send(8'h90, 16'h0000, 16'h0000); settle();
    chk(halt_cnt == 0, "R8 halt refused", 16'(halt_cnt), 16'h0000);

    // R6 enable firmware by writing bit 7
    send(8'hC4, 16'hFF01, 16'h0080); settle();
    chk(fw_enabled == 1'b1, "R6 enable bit", {15'h0, fw_enabled}, 16'h0001);
    chk(n_access == acc0, "R6 status write no bus", 16'(n_access), 16'(acc0));
    rd(8'hE4, 16'hFF01, 16'h0080, "R6 status running");
    cpu_halted = 1'b1;
    rd(8'hE4, 16'hFF01, 16'h00C0, "R6 status halted");
    rd(8'hEC, 16'hFF00, 16'h00C0, "R6 status word read");
    cpu_halted = 1'b0;
    send(8'hC4, 16'hFF00, 16'h0000); settle();
    chk(fw_enabled == 1'b1, "R6 FF00 write ignored", {15'h0, fw_enabled}, 16'h0001);

    // R8 accepted when enabled: one pulse
    send(8'h90, 16'h0000, 16'h0000); settle();
    chk(halt_cnt == 1, "R8 halt one pulse", 16'(halt_cnt), 16'h0001);

    // R2 R3 byte reads in map
    rd(8'hE4, 16'h0011, {8'h00, pat(8'h08)[7:0]}, "R3 odd byte read");
    chk(last_be == 2'b01 && last_inmap, "R2 R3 odd lane inmap", {13'h0, last_inmap, last_be}, 16'h0005);
    rd(8'hE4, 16'h0010, {pat(8'h08)[15:8], 8'h00}, "R3 even byte read");
    chk(last_be == 2'b10, "R3 even lane", {14'h0, last_be}, 16'h0002);

    // R7 out of map reaches the bus
    acc0 = n_access;
    rd(8'hE0, 16'hFF01, {8'h00, pat(8'h80)[7:0]}, "R7 out-of-map FF01");
    chk(n_access == acc0 + 1 && !last_inmap, "R7 R2 bus used, map out", 16'(n_access - acc0), 16'h0001);

    // R5 word alignment
    rd(8'hEC, 16'h0021, pat(8'h10), "R5 misaligned word read");
    chk(last_addr == 16'h0020 && last_be == 2'b11, "R5 address bit0 cleared", last_addr, 16'h0020);
    rd(8'hE8, 16'h0030, pat(8'h18), "R2 word out of map");
    chk(!last_inmap, "R2 E8 map out", {15'h0, last_inmap}, 16'h0000);

    // R4 byte writes
    send(8'hC4, 16'h0041, 16'h1234); settle();
    chk(last_be == 2'b01, "R4 odd write lane", {14'h0, last_be}, 16'h0001);
    rd(8'hEC, 16'h0040, {pat(8'h20)[15:8], 8'h34}, "R4 odd write readback");
    send(8'hC4, 16'h0042, 16'hABCD); settle();
    chk(last_be == 2'b10, "R4 even write lane", {14'h0, last_be}, 16'h0002);
    rd(8'hEC, 16'h0042, {8'hAB, pat(8'h21)[7:0]}, "R4 even write readback");

    // R9 unknown opcodes
    acc0 = n_access;
    send(8'h55, 16'h0050, 16'hFFFF); settle();
    send(8'hC5, 16'hFF01, 16'h0000); settle();
    chk(n_access == acc0, "R9 no bus access", 16'(n_access - acc0), 16'h0000);
    chk(fw_enabled == 1'b1, "R9 status kept", {15'h0, fw_enabled}, 16'h0001);

    // R1 R11 busy with slow grant, competing command dropped
    gnt_delay = 6;
    exp_q.push_back(pat(8'h30)); tag_q.push_back("R11 slow grant read");
    send(8'hE8, 16'h0060, 16'h0000);
    chk(busy && !cmd_ready, "R1 busy during access", {14'h0, busy, cmd_ready}, 16'h0002);
    cmd_valid = 1'b1; cmd_op = 8'hC4; cmd_addr = 16'h0063; cmd_wdata = 16'h0000;
    repeat (3) @(negedge clk);
    chk(bus_req && bus_addr == 16'h0060, "R11 request held", bus_addr, 16'h0060);
    cmd_valid = 1'b0;
    settle();
    gnt_delay = 1;
    rd(8'hEC, 16'h0062, pat(8'h31), "R1 rejected write had no effect");

    // R10 back-pressure
    bp_on = 1'b1;
    rd(8'hEC, 16'h0070, pat(8'h38), "R10 read under back-pressure a");
    rd(8'hE4, 16'h0073, {8'h00, pat(8'h39)[7:0]}, "R10 read under back-pressure b");
    rd(8'hE4, 16'hFF01, 16'h0080, "R10 status under back-pressure");
    bp_on = 1'b0;

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 16'h0000, 16'h0001);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule